// File: doc/BRIEF.md
# Line-Sync Locked Clock Divider

This block derives a sampling clock from a fast system clock by dividing it by a power of two, and keeps that clock phase-aligned to the falling edge of an incoming horizontal sync. It is a fully digital stand-in for an external loop chip. The sync is sampled twice per system clock: once on the rising edge and once on the falling edge. Both samples are presented together at the rising edge, so the position of the sync edge is known to half a system clock. The divided clock leaves through two bits, one for each half of a double-rate output pin. The bit for the early half can be taken from a copy of the divider one clock older, which moves the output edge by half a system clock.

At every sync edge a comparator looks at two things: how many divider wraps occurred during the line, and where the divider stands at the moment of the edge. From these it casts a vote of up, down or hold. Votes are summed over a window of lines. A single one-step correction is made only when the sum reaches a threshold: the divider either advances by two for one clock or pauses for one clock. A lock flag reports a run of quiet windows, and is dropped when a correction is made or when the sync goes missing.

Top module: `hsync_lock_divider`

## Requirements
- R1: While rst_n is low, out_hi, out_lo, div_dbg and locked are all 0.
- R2: With no pending correction, the internal divider count rises by one each clock and wraps modulo 2^DIV_W, whether or not sync is present. out_lo and div_dbg equal the count's top bit one clock later, giving a square wave with a period of 2^DIV_W clocks.
- R3: A sync edge is detected in the clock where sync_rise is 0 and was 1 in the clock before. A low-to-high change is not an edge, and two edges can never occur in consecutive clocks.
- R4: At each sync edge an early flag is loaded with the inverse of sync_fall. While the flag is 1, out_hi equals out_lo delayed by one clock. While it is 0, out_hi equals out_lo.
- R5: At a sync edge, let L be the number of divider wraps (top count value back to 0) since the previous edge. The vote is +1 if L < LINE_CYC and −1 if L > LINE_CYC. If L = LINE_CYC, the vote comes from the count at the edge: 0 gives 0, a count with its top bit set gives +1, and any other count gives −1.
- R6: The running vote sum is compared at each edge. When it reaches +THRESH, the count advances by 2 in the next clock. When it reaches −THRESH, the count holds for the next clock. In both cases the sum and the window are cleared.
- R7: A correction lasts exactly one clock. A window ends without correction after WIN_LINES edges, and then the sum is cleared.
- R8: locked rises in the clock after the edge that ends the LOCK_WINS-th consecutive window closed without correction.
- R9: Any correction clears locked and the count of quiet windows.
- R10: After 2·LINE_CYC·2^DIV_W clocks without a sync edge, locked and the quiet-window count are cleared.
- R11: With a sync period of exactly LINE_CYC·2^DIV_W clocks at a fixed phase, the count at each edge converges to 0 and locked asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_rise | input | 1 | Sync sample taken at the rising clock edge |
| sync_fall | input | 1 | Sync sample taken at the preceding falling clock edge |
| out_hi | output | 1 | Output-clock bit for the first half of the double-rate pin |
| out_lo | output | 1 | Output-clock bit for the second half of the double-rate pin |
| div_dbg | output | 1 | Plain copy of the divider top bit |
| locked | output | 1 | Loop has seen LOCK_WINS quiet windows in a row |

## Verification
A wrong divider step or a miscounted wrap changes the phase of out_lo. That shift appears at the ports within one output period, and every later edge stays displaced. A wrong vote, sum or threshold shows up first as a correction made one line early or late. It then shows as a phase that settles elsewhere, and as locked rising or falling in a different clock. A wrong early flag breaks the one-clock relation between out_hi and out_lo at once. For this reason a cycle-exact model compared on every clock exposes any such fault within a few lines of sync.

// File: rtl/hsld_pkg.sv
package hsld_pkg;
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADD  = 2'd1,
    CORR_SKIP = 2'd2
  } corr_e;
endpackage

// File: rtl/hsld_divider.sv
module hsld_divider
  import hsld_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  corr_e            corr,
  input  logic             early,
  output logic [DIV_W-1:0] cnt,
  output logic             wrap,
  output logic             out_hi,
  output logic             out_lo,
  output logic             div_dbg
);
  localparam int MSB = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d_q, cnt_nx;
  logic [DIV_W:0]   sum;
  logic [1:0]       step;
  logic             hi_nx;
  logic             hi_q, lo_q, dbg_q;

  // Next-state: step of 1, or 2 / 0 for a single correction clock
  always_comb begin
    case (corr)
      CORR_ADD:  step = 2'd2;
      CORR_SKIP: step = 2'd0;
      default:   step = 2'd1;
    endcase
    sum    = {1'b0, cnt_q} + (DIV_W + 1)'(step);
    cnt_nx = sum[DIV_W-1:0];
    hi_nx  = early ? cnt_d_q[MSB] : cnt_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cnt_d_q <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      dbg_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      cnt_d_q <= cnt_q;
      hi_q    <= hi_nx;
      lo_q    <= cnt_q[MSB];
      dbg_q   <= cnt_q[MSB];
    end
  end

  assign cnt     = cnt_q;
  assign wrap    = sum[DIV_W];
  assign out_hi  = hi_q;
  assign out_lo  = lo_q;
  assign div_dbg = dbg_q;
endmodule

// File: rtl/hsld_detector.sv
module hsld_detector #(
  parameter int DIV_W    = 5,
  parameter int LINE_CYC = 667
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rise,
  input  logic              sync_fall,
  input  logic [DIV_W-1:0]  cnt,
  input  logic              wrap,
  output logic              line_edge,
  output logic              early,
  output logic signed [1:0] vote
);
  localparam int LC_W = $clog2(LINE_CYC + 2);
  localparam logic [LC_W-1:0] LC_EXP = LC_W'(LINE_CYC);
  localparam logic [LC_W-1:0] LC_SAT = LC_W'(LINE_CYC + 1);

  logic            prev_q, early_q, early_nx, edge_w;
  logic [LC_W-1:0] lc_q, lc_nx;

  always_comb begin
    edge_w   = prev_q & ~sync_rise;
    early_nx = edge_w ? ~sync_fall : early_q;
    if (edge_w)
      lc_nx = {{(LC_W-1){1'b0}}, wrap};
    else if (wrap && (lc_q < LC_SAT))
      lc_nx = lc_q + 1'b1;
    else
      lc_nx = lc_q;

    // Frequency first, phase when the wrap count is right
    if (lc_q < LC_EXP)       vote = 2'sb01;
    else if (lc_q > LC_EXP)  vote = 2'sb11;
    else if (cnt == '0)      vote = 2'sb00;
    else if (cnt[DIV_W-1])   vote = 2'sb01;
    else                     vote = 2'sb11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      early_q <= 1'b0;
      lc_q    <= '0;
    end else begin
      prev_q  <= sync_rise;
      early_q <= early_nx;
      lc_q    <= lc_nx;
    end
  end

  assign line_edge = edge_w;
  assign early     = early_q;
endmodule

// File: rtl/hsld_loop.sv
module hsld_loop
  import hsld_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int LINE_CYC  = 667,
  parameter int WIN_LINES = 16,
  parameter int THRESH    = 4,
  parameter int LOCK_WINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_edge,
  input  logic signed [1:0] vote,
  output corr_e             corr,
  output logic              locked,
  output logic              timeout
);
  localparam int LIMIT = 2 * LINE_CYC * (2 ** DIV_W);
  localparam int ID_W  = $clog2(LIMIT + 1);
  localparam int WL_W  = $clog2(WIN_LINES + 1);
  localparam int LK_W  = $clog2(LOCK_WINS + 1);
  localparam int ACC_W = $clog2(THRESH + 1) + 2;
  localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(THRESH);
  localparam logic signed [ACC_W-1:0] TH_N = -TH_P;

  corr_e                   corr_q, corr_nx;
  logic signed [ACC_W-1:0] acc_q, acc_nx, acc_new, vote_ext;
  logic [WL_W-1:0]         wl_q, wl_nx;
  logic [LK_W-1:0]         lk_q, lk_nx;
  logic [ID_W-1:0]         idle_q, idle_nx;
  logic                    lock_q, lock_nx, tmo;

  always_comb begin
    vote_ext = {{(ACC_W-2){vote[1]}}, vote};
    acc_new  = acc_q + vote_ext;
    corr_nx  = CORR_NONE;
    acc_nx   = acc_q;
    wl_nx    = wl_q;
    lk_nx    = lk_q;
    idle_nx  = idle_q;
    lock_nx  = lock_q;
    tmo      = 1'b0;
    if (line_edge) begin
      idle_nx = '0;
      if (acc_new >= TH_P || acc_new <= TH_N) begin
        corr_nx = (acc_new >= TH_P) ? CORR_ADD : CORR_SKIP;
        acc_nx  = '0;
        wl_nx   = '0;
        lk_nx   = '0;
        lock_nx = 1'b0;
      end else if (wl_q == WL_W'(WIN_LINES - 1)) begin
        acc_nx = '0;
        wl_nx  = '0;
        lk_nx  = (lk_q == LK_W'(LOCK_WINS)) ? lk_q : lk_q + 1'b1;
        if (lk_nx == LK_W'(LOCK_WINS)) lock_nx = 1'b1;
      end else begin
        acc_nx = acc_new;
        wl_nx  = wl_q + 1'b1;
      end
    end else if (idle_q == ID_W'(LIMIT)) begin
      tmo     = 1'b1;
      lock_nx = 1'b0;
      lk_nx   = '0;
    end else begin
      idle_nx = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= CORR_NONE;
      acc_q  <= '0;
      wl_q   <= '0;
      lk_q   <= '0;
      idle_q <= '0;
      lock_q <= 1'b0;
    end else begin
      corr_q <= corr_nx;
      acc_q  <= acc_nx;
      wl_q   <= wl_nx;
      lk_q   <= lk_nx;
      idle_q <= idle_nx;
      lock_q <= lock_nx;
    end
  end

  assign corr    = corr_q;
  assign locked  = lock_q;
  assign timeout = tmo;
endmodule

// File: rtl/hsync_lock_divider.sv
module hsync_lock_divider
  import hsld_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int LINE_CYC  = 667,
  parameter int WIN_LINES = 16,
  parameter int THRESH    = 4,
  parameter int LOCK_WINS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rise,
  input  logic sync_fall,
  output logic out_hi,
  output logic out_lo,
  output logic div_dbg,
  output logic locked
);
  logic [DIV_W-1:0]  cnt;
  logic              wrap, line_edge, early, timeout;
  logic signed [1:0] vote;
  corr_e             corr;

  hsld_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .corr(corr), .early(early),
    .cnt(cnt), .wrap(wrap),
    .out_hi(out_hi), .out_lo(out_lo), .div_dbg(div_dbg)
  );

  hsld_detector #(.DIV_W(DIV_W), .LINE_CYC(LINE_CYC)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .sync_fall(sync_fall),
    .cnt(cnt), .wrap(wrap),
    .line_edge(line_edge), .early(early), .vote(vote)
  );

  hsld_loop #(
    .DIV_W(DIV_W), .LINE_CYC(LINE_CYC), .WIN_LINES(WIN_LINES),
    .THRESH(THRESH), .LOCK_WINS(LOCK_WINS)
  ) u_loop (
    .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .vote(vote),
    .corr(corr), .locked(locked), .timeout(timeout)
  );
endmodule

// File: rtl/hsld_checker.sv
module hsld_checker
  import hsld_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cnt,
  input corr_e            corr,
  input logic             early,
  input logic             line_edge,
  input logic             timeout,
  input logic             locked,
  input logic             out_hi,
  input logic             out_lo,
  input logic             div_dbg
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (!out_hi && !out_lo && !div_dbg && !locked);
    end
  end

  a_r2_free_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (corr == CORR_NONE) |=> (cnt == DIV_W'($past(cnt) + 1'b1)));

  a_r3_edge_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    line_edge |=> !line_edge);

  a_r4_direct_half: assert property (@(posedge clk) disable iff (!rst_n)
    !early |=> (out_hi == out_lo));

  a_r4_delayed_half: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (out_hi == $past(out_lo)));

  a_r6_add_two: assert property (@(posedge clk) disable iff (!rst_n)
    (corr == CORR_ADD) |=> (cnt == DIV_W'($past(cnt) + 2'd2)));

  a_r6_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (corr == CORR_SKIP) |=> (cnt == $past(cnt)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (corr != CORR_NONE) |=> (corr == CORR_NONE));

  a_r8_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_edge));

  a_r9_corr_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (corr != CORR_NONE) |-> !locked);

  a_r10_timeout_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !locked);
endmodule

bind hsync_lock_divider hsld_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .corr(corr), .early(early),
  .line_edge(line_edge), .timeout(timeout), .locked(locked),
  .out_hi(out_hi), .out_lo(out_lo), .div_dbg(div_dbg)
);

// File: tb/hsync_lock_divider_tb_top.sv
`timescale 1ns/1ps
module hsync_lock_divider_tb_top;
  localparam int DIV_W     = 4;
  localparam int LINE_CYC  = 5;
  localparam int WIN_LINES = 4;
  localparam int THRESH    = 2;
  localparam int LOCK_WINS = 3;
  localparam int M         = 1 << DIV_W;
  localparam int LINE_CLK  = LINE_CYC * M;
  localparam int LIMIT     = 2 * LINE_CLK;

  logic clk = 1'b0;
  logic rst_n, sync_rise, sync_fall;
  logic out_hi, out_lo, div_dbg, locked;

  always #2.5 clk = ~clk;

  hsync_lock_divider #(
    .DIV_W(DIV_W), .LINE_CYC(LINE_CYC), .WIN_LINES(WIN_LINES),
    .THRESH(THRESH), .LOCK_WINS(LOCK_WINS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .sync_fall(sync_fall),
    .out_hi(out_hi), .out_lo(out_lo), .div_dbg(div_dbg), .locked(locked)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // sync source in half-clock steps
  int per_h = 2 * LINE_CLK, off_h = 0, low_h = 20, hpos = 0;
  bit sync_on = 0;
  int cur_r = 1, cur_f = 1;

  // reference model state
  int m_cnt, m_cntd, m_corr, m_lc, m_acc, m_wl, m_lk, m_lock, m_idle;
  int m_early, m_sprev, m_hi, m_lo, m_dbg;
  int last_phase = -1, ncorr = 0, early_seen = 0, saw_unlock = 0, prev_lock = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sval(int h);
    int ph;
    if (!sync_on) return 1;
    ph = ((h + off_h) % per_h + per_h) % per_h;
    return (ph < low_h) ? 0 : 1;
  endfunction

  task automatic mreset();
    m_cnt = 0; m_cntd = 0; m_corr = 0; m_lc = 0; m_acc = 0; m_wl = 0;
    m_lk = 0; m_lock = 0; m_idle = 0; m_early = 0; m_sprev = 0;
    m_hi = 0; m_lo = 0; m_dbg = 0;
  endtask

  task automatic mupdate(int r, int f);
    int e, stp, sum, wrap, vote, a;
    int n_cnt, n_lc, n_early, n_corr, n_acc, n_wl, n_lk, n_lock, n_idle;
    e    = (m_sprev == 1 && r == 0);
    stp  = (m_corr == 1) ? 2 : (m_corr == 2) ? 0 : 1;
    sum  = m_cnt + stp;
    wrap = (sum >= M);
    n_cnt = sum % M;
    if (m_lc < LINE_CYC) vote = 1;
    else if (m_lc > LINE_CYC) vote = -1;
    else if (m_cnt == 0) vote = 0;
    else if (m_cnt >= M / 2) vote = 1;
    else vote = -1;
    if (e) n_lc = wrap;
    else if (wrap && m_lc < LINE_CYC + 1) n_lc = m_lc + 1;
    else n_lc = m_lc;
    n_early = e ? (f == 0) : m_early;
    n_corr = 0; n_acc = m_acc; n_wl = m_wl; n_lk = m_lk;
    n_lock = m_lock; n_idle = m_idle;
    if (e) begin
      last_phase = m_cnt;
      n_idle = 0;
      a = m_acc + vote;
      if (a >= THRESH || a <= -THRESH) begin
        n_corr = (a >= THRESH) ? 1 : 2;
        ncorr++;
        n_acc = 0; n_wl = 0; n_lk = 0; n_lock = 0;
      end else if (m_wl == WIN_LINES - 1) begin
        n_acc = 0; n_wl = 0;
        n_lk = (m_lk == LOCK_WINS) ? m_lk : m_lk + 1;
        if (n_lk == LOCK_WINS) n_lock = 1;
      end else begin
        n_acc = a; n_wl = m_wl + 1;
      end
    end else if (m_idle == LIMIT) begin
      n_lock = 0; n_lk = 0;
    end else begin
      n_idle = m_idle + 1;
    end
    m_hi   = m_early ? (m_cntd >= M / 2) : (m_cnt >= M / 2);
    m_lo   = (m_cnt >= M / 2);
    m_dbg  = m_lo;
    m_cntd = m_cnt;
    m_cnt  = n_cnt;
    m_lc = n_lc; m_early = n_early; m_corr = n_corr; m_acc = n_acc;
    m_wl = n_wl; m_lk = n_lk; m_lock = n_lock; m_idle = n_idle;
    m_sprev = r;
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) mreset(); else mupdate(cur_r, cur_f);
    @(negedge clk);
    chk(out_lo == m_lo[0],   "R2 out_lo",  out_lo,  m_lo);
    chk(div_dbg == m_dbg[0], "R2 div_dbg", div_dbg, m_dbg);
    chk(out_hi == m_hi[0],   "R4 out_hi",  out_hi,  m_hi);
    chk(locked == m_lock[0], "R8 locked",  locked,  m_lock);
    if (m_early) early_seen = 1;
    if (prev_lock && !m_lock) saw_unlock = 1;
    prev_lock = m_lock;
    hpos += 2;
    cur_r = sval(hpos);
    cur_f = sval(hpos - 1);
    sync_rise = cur_r[0];
    sync_fall = cur_f[0];
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_up();
  end

  initial begin
    int ncorr0;
    rst_n = 1'b1; sync_rise = 1'b1; sync_fall = 1'b1;
    #1 rst_n = 1'b0;
    mreset();
    run(4);
    // R1: reset state at the ports
    chk(!out_hi && !out_lo && !div_dbg, "R1 clocks low in reset", out_lo, 0);
    chk(!locked, "R1 locked low in reset", locked, 0);
    @(negedge clk) rst_n = 1'b1;
    // R2, R11 free run without sync; R10 no lock without sync
    run(300);
    chk(!locked, "R10 no lock without sync", locked, 0);
    // R11: nominal period, even offset (early flag 0)
    sync_on = 1; off_h = 0;
    run(60 * LINE_CLK);
    chk(locked, "R11 lock at nominal phase", locked, 1);
    chk(last_phase == 0, "R11 phase converged", last_phase, 0);
    // R4, R9: phase jump to an odd half-clock offset
    off_h = 37; saw_unlock = 0;
    run(60 * LINE_CLK);
    chk(saw_unlock == 1, "R9 lock drops on correction", saw_unlock, 1);
    chk(early_seen == 1, "R4 early half selected", early_seen, 1);
    chk(locked, "R11 relock after phase jump", locked, 1);
    chk(last_phase == 0, "R11 phase after jump", last_phase, 0);
    // R5, R6, R7: line longer than expected keeps correcting
    ncorr0 = ncorr;
    per_h = 2 * (LINE_CLK + 4);
    run(20 * LINE_CLK);
    chk(ncorr > ncorr0, "R5 R6 corrections on long line", ncorr - ncorr0, 1);
    chk(!locked, "R7 no lock while drifting", locked, 0);
    // R8: back to nominal, relock
    per_h = 2 * LINE_CLK; off_h = 0;
    run(60 * LINE_CLK);
    chk(locked, "R8 lock after quiet windows", locked, 1);
    // R10: sync removed
    sync_on = 0;
    run(LIMIT - LINE_CLK);
    chk(locked, "R10 lock held before timeout", locked, 1);
    run(2 * LINE_CLK);
    chk(!locked, "R10 lock cleared after timeout", locked, 0);
    // R3: a rising sync edge alone is not a sync edge
    ncorr0 = ncorr;
    run(40);
    chk(!locked, "R3 no edge from held-high sync", locked, 0);
    finish_up();
  end
endmodule